// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Controller

This block is the transmit half of a serial port. One shift path serves two modes. In asynchronous mode a free-running divider counts pulses of the base clock enable and gives one bit-rate tick for every sixteen of them. A host write loads the transmit buffer, and the frame does not start until the next tick. The frame is then sent one bit per tick: a low start bit, seven or eight data bits with the least significant bit first, and a high stop bit.

In synchronous mode the buffer's eight bits go out on the data pin, least significant bit first, one bit per shift clock event. The shift clock is either made inside the block from the base clock enable and driven out, or taken from an external pin. An external clock passes through a two-flop synchronizer, and a configuration bit chooses whether its rising or its falling edge shifts. When the last bit of a frame or transfer is complete, the busy flag drops and the transmit-done interrupt pulses for one cycle.

The controller is built around one state machine. ST_IDLE goes to ST_ARM on a write in asynchronous mode, or to ST_SYNC on a write in synchronous mode. ST_ARM goes to ST_START on a tick. ST_START goes to ST_DATA on the next tick. ST_DATA goes to ST_STOP on the tick after the last data bit. ST_STOP goes back to ST_IDLE on the tick that ends the stop bit. ST_SYNC goes back to ST_IDLE on the shift event that follows the eighth bit.

Top module: `sertx_ctrl`

## Requirements
- R1: The bit-rate tick occurs on every 16th high cycle of `base_tick`. The divider runs freely from reset, so the first tick comes on the 16th such cycle after reset.
- R2: An accepted asynchronous write starts the frame on the first tick that falls in a later cycle. `txd` goes low at that tick's clock edge. A tick in the same cycle as the write is not used.
- R3: An asynchronous frame lasts one tick period per bit. It is a start bit (0), then the data bits least significant bit first, then a stop bit (1). There are 8 data bits when `len7`=0 and 7 data bits (bits 6..0) when `len7`=1. `len7` is taken at the write.
- R4: While `busy` is 0, `txd` and `sclk_out` are both 1. After reset `busy` and `tx_done` are 0.
- R5: `busy` goes to 1 at the edge that accepts a write. At the edge that ends the frame, `busy` goes back to 0 and `tx_done` is 1 for exactly one cycle.
- R6: A write made while `busy` is 1 is ignored. The frame in progress and its data are unchanged.
- R7: Synchronous mode is `mode_sync`=1. With the internal clock (`sclk_ext`=0), `sclk_oe` is 1. While busy, `sclk_out` toggles on each `base_tick` cycle, and its first toggle is a fall. Each rise of `sclk_out` puts the next of the 8 bits on `txd`, least significant bit first. The rise after the eighth bit ends the transfer.
- R8: With the external clock (`sclk_ext`=1), `sclk_oe` is 0 and `sclk_out` stays 1. The selected edge of `sclk_in` shifts: the rising edge when `sclk_fall`=0, the falling edge when `sclk_fall`=1. A level change of `sclk_in` that is sampled at edge k shows its effect on `txd` after edge k+2. Each selected edge presents the next bit, and the ninth selected edge ends the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | Serial base clock enable, one cycle per pulse |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | DATA_W | Host write data |
| mode_sync | input | 1 | 0 asynchronous, 1 synchronous |
| len7 | input | 1 | Asynchronous frames carry 7 data bits when 1 |
| sclk_ext | input | 1 | Synchronous shift clock: 0 internal (driven out), 1 external |
| sclk_fall | input | 1 | External shift edge: 0 rising, 1 falling |
| sclk_in | input | 1 | External shift clock pin |
| txd | output | 1 | Serial data output |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Output enable of the shift clock pin |
| busy | output | 1 | A frame or transfer is in progress |
| tx_done | output | 1 | One-cycle pulse when a frame or transfer ends |

## Verification
Asynchronous frames are sent with `base_tick` high on every cycle and with `base_tick` high on every third cycle. The write falls at varying offsets from the divider phase, which shows that the start waits for a tick in a later cycle and that the sixteen-count divider is never reset by a write. Eight-bit and seven-bit frames use data whose top bit is set, so a wrong frame length shows up as a visible difference. A write placed in the middle of a frame shows whether buffer data could be overwritten. Synchronous transfers are run with the internal clock and then with an external clock on each edge polarity, using slow external clock periods, to separate the edge select, the synchronizer latency and the end on the ninth event.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_SYNC
    } tx_state_e;

endpackage

// File: rtl/sertx_div.sv
module sertx_div #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    output logic bit_tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (base_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the count wraps after the last state; the tick marks that pulse
    assign bit_tick = base_tick && (&cnt_q);
endmodule

// File: rtl/sertx_clkin.sv
module sertx_clkin #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic fall_sel,
    output logic edge_evt
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], sclk_in};
        end
    end

    logic now_lvl, old_lvl;
    assign now_lvl  = pipe_q[SYNC_STAGES-1];
    assign old_lvl  = pipe_q[SYNC_STAGES];
    assign edge_evt = fall_sel ? (old_lvl && !now_lvl) : (now_lvl && !old_lvl);
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              bit_tick,
    input  logic              ext_evt,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_sync,
    input  logic              len7,
    input  logic              sclk_ext,
    output logic              txd,
    output logic              sclk_q,
    output logic              busy,
    output logic              tx_done
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] NB_FULL  = CW'(DATA_W);
    localparam logic [CW-1:0] NB_SHORT = CW'(DATA_W - 1);

    tx_state_e         state_q, state_n;
    logic [DATA_W-1:0] shreg_q;
    logic [CW-1:0]     idx_q;
    logic              len7_q;
    logic [CW-1:0]     nbits;
    logic              sh_evt;
    logic              int_fall;

    assign nbits    = len7_q ? NB_SHORT : NB_FULL;
    assign sh_evt   = sclk_ext ? ext_evt : (base_tick && !sclk_q);
    assign int_fall = !sclk_ext && base_tick && sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_en) state_n = mode_sync ? ST_SYNC : ST_ARM;
            ST_ARM:   if (bit_tick) state_n = ST_START;
            ST_START: if (bit_tick) state_n = ST_DATA;
            ST_DATA:  if (bit_tick && (idx_q == nbits)) state_n = ST_STOP;
            ST_STOP:  if (bit_tick) state_n = ST_IDLE;
            ST_SYNC:  if (sh_evt && (idx_q == NB_FULL)) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd     <= 1'b1;
            sclk_q  <= 1'b1;
            busy    <= 1'b0;
            tx_done <= 1'b0;
            shreg_q <= '0;
            idx_q   <= '0;
            len7_q  <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        shreg_q <= wr_data;
                        len7_q  <= len7;
                        busy    <= 1'b1;
                        idx_q   <= '0;
                        sclk_q  <= 1'b1;
                    end
                end
                ST_ARM: begin
                    if (bit_tick) txd <= 1'b0;
                end
                ST_START: begin
                    if (bit_tick) begin
                        txd     <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        idx_q   <= CW'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_tick) begin
                        if (idx_q == nbits) begin
                            txd <= 1'b1;
                        end else begin
                            txd     <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_tick) begin
                        busy    <= 1'b0;
                        tx_done <= 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (int_fall) sclk_q <= 1'b0;
                    if (sh_evt) begin
                        sclk_q <= 1'b1;
                        if (idx_q == NB_FULL) begin
                            txd     <= 1'b1;
                            busy    <= 1'b0;
                            tx_done <= 1'b1;
                        end else begin
                            txd     <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_sync,
    input  logic              len7,
    input  logic              sclk_ext,
    input  logic              sclk_fall,
    input  logic              sclk_in,
    output logic              txd,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              busy,
    output logic              tx_done
);
    logic bit_tick;
    logic ext_evt;

    sertx_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .bit_tick  (bit_tick)
    );

    sertx_clkin #(.SYNC_STAGES(2)) u_clkin (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .fall_sel (sclk_fall),
        .edge_evt (ext_evt)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .bit_tick  (bit_tick),
        .ext_evt   (ext_evt),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mode_sync (mode_sync),
        .len7      (len7),
        .sclk_ext  (sclk_ext),
        .txd       (txd),
        .sclk_q    (sclk_out),
        .busy      (busy),
        .tx_done   (tx_done)
    );

    assign sclk_oe = mode_sync && !sclk_ext;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic mode_sync,
    input logic sclk_ext,
    input logic txd,
    input logic sclk_out,
    input logic busy,
    input logic tx_done
);
    p_idle_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && sclk_out));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tx_done);

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!busy && $past(busy)));

    p_async_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_sync && !$stable(txd)) |-> $past(bit_tick));

    p_int_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_sync && !sclk_ext && !$stable(txd)) |-> $rose(sclk_out));

    p_ext_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_sync && sclk_ext) |-> sclk_out);
endmodule

bind sertx_ctrl sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .mode_sync (mode_sync),
    .sclk_ext  (sclk_ext),
    .txd       (txd),
    .sclk_out  (sclk_out),
    .busy      (busy),
    .tx_done   (tx_done)
);

// File: tb/sertx_ctrl_test.sv
module sertx_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mode_sync = 1'b0;
    logic       len7 = 1'b0;
    logic       sclk_ext = 1'b0;
    logic       sclk_fall = 1'b0;
    logic       sclk_in = 1'b1;
    logic       txd, sclk_out, sclk_oe, busy, tx_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_every = 1;
    int tick_cnt = 0;

    always #10 clk = ~clk;

    sertx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
        .wr_data(wr_data), .mode_sync(mode_sync), .len7(len7),
        .sclk_ext(sclk_ext), .sclk_fall(sclk_fall), .sclk_in(sclk_in),
        .txd(txd), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .busy(busy), .tx_done(tx_done)
    );

    // base clock enable pattern
    always @(negedge clk) begin
        tick_cnt = tick_cnt + 1;
        base_tick <= ((tick_cnt % tick_every) == 0);
    end

    // behavioural reference model
    logic m_txd, m_busy, m_done, m_sclk, m_sync, m_ign;
    logic h1, h2, h3;
    int   m_div;
    logic q[$];

    always @(posedge clk or negedge rst_n) begin
        logic tick, ev, ev_ext;
        if (!rst_n) begin
            m_txd = 1; m_busy = 0; m_done = 0; m_sclk = 1; m_sync = 0; m_ign = 0;
            h1 = 1; h2 = 1; h3 = 1; m_div = 0; q.delete();
        end else begin
            m_done = 0;
            tick = 0;
            if (base_tick) begin
                tick = (m_div == 15);
                m_div = (m_div + 1) % 16;
            end
            ev_ext = sclk_fall ? (h3 && !h2) : (h2 && !h3);
            h3 = h2; h2 = h1; h1 = sclk_in;
            if (m_busy) begin
                if (wr_en) m_ign = 1;
                if (!m_sync) begin
                    if (tick) begin
                        if (q.size() > 0) m_txd = q.pop_front();
                        else begin m_busy = 0; m_done = 1; end
                    end
                end else begin
                    ev = 0;
                    if (sclk_ext) ev = ev_ext;
                    else if (base_tick) begin
                        if (m_sclk) m_sclk = 0;
                        else ev = 1;
                    end
                    if (ev) begin
                        m_sclk = 1;
                        if (q.size() > 0) m_txd = q.pop_front();
                        else begin m_busy = 0; m_done = 1; m_txd = 1; end
                    end
                end
            end else if (wr_en) begin
                int n;
                m_busy = 1; m_sync = mode_sync; m_ign = 0; q.delete();
                n = mode_sync ? 8 : (len7 ? 7 : 8);
                if (!mode_sync) q.push_back(1'b0);
                for (int i = 0; i < n; i++) q.push_back(wr_data[i]);
                if (!mode_sync) q.push_back(1'b1);
            end
        end
    end

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        string ttag;
        cycles++;
        if (rst_n) begin
            if (!m_busy)            ttag = "R4";
            else if (m_ign)         ttag = "R6";
            else if (!m_sync)       ttag = "R1 R2 R3";
            else if (sclk_ext)      ttag = "R8";
            else                    ttag = "R7";
            check1(ttag, "txd", txd, m_txd);
            check1("R5", "busy", busy, m_busy);
            check1("R5", "tx_done", tx_done, m_done);
            check1(m_sync && m_busy && !sclk_ext ? "R7" : "R4 R8", "sclk_out", sclk_out, m_sclk);
            check1("R7 R8", "sclk_oe", sclk_oe, mode_sync && !sclk_ext);
        end
    end

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic ext_clock(input int half, input int toggles);
        for (int t = 0; t < toggles; t++) begin
            repeat (half) @(negedge clk);
            sclk_in = ~sclk_in;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check1("R4", "reset txd", txd, 1'b1);
        check1("R4", "reset busy", busy, 1'b0);
        check1("R4", "reset tx_done", tx_done, 1'b0);
        check1("R4", "reset sclk_out", sclk_out, 1'b1);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 R2 R3: eight-bit async frames at several divider phases
        write(8'hA5);
        wait_idle();
        repeat (7) @(negedge clk);
        write(8'h81);
        // R6: a write in mid frame must change nothing
        repeat (40) @(negedge clk);
        write(8'h3C);
        wait_idle();

        // R3: seven-bit frame, bit 7 set must be dropped
        len7 = 1;
        write(8'hFE);
        wait_idle();
        len7 = 0;

        // slower base clock enable
        tick_every = 3;
        repeat (11) @(negedge clk);
        write(8'h00);
        wait_idle();
        write(8'hFF);
        wait_idle();

        // R7: synchronous, internal clock
        tick_every = 2;
        mode_sync = 1; sclk_ext = 0;
        repeat (3) @(negedge clk);
        write(8'h96);
        wait_idle();
        write(8'h01);
        repeat (6) @(negedge clk);
        write(8'h77);
        wait_idle();

        // R8: synchronous, external clock, rising edge
        sclk_ext = 1; sclk_fall = 0; sclk_in = 1;
        repeat (3) @(negedge clk);
        write(8'h5A);
        ext_clock(4, 20);
        wait_idle();

        // R8: falling edge
        sclk_fall = 1;
        repeat (3) @(negedge clk);
        write(8'hC3);
        ext_clock(5, 20);
        wait_idle();

        mode_sync = 0; sclk_ext = 0; sclk_fall = 0;
        tick_every = 1;
        repeat (5) @(negedge clk);
        write(8'h6B);
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule